// File: doc/BRIEF.md
# ALU with zero flag

This block is a purely combinational arithmetic-logic unit for a simple datapath. It takes two operand words and a 4-bit operation selector. It returns the result word together with a single flag that is high whenever every bit of that result is clear. Branch logic tests that flag after a subtraction to decide both "branch if equal" and "branch if not equal". Address generation for loads and stores uses the add operation.

The supported operations are bitwise AND, OR and NOR, wrapping addition and subtraction, and a signed less-than comparison. Selector values outside the supported set give a zero word. Add and subtract share one adder. The comparison reuses the adder's difference and the operand signs, so no second subtractor is needed. There is no clock or state inside the block.

Top module: `arith_logic_unit`

## Requirements
- R1: Selector 4'b0000 makes the result the bitwise AND of the two operands.
- R2: Selector 4'b0001 makes the result the bitwise OR of the two operands.
- R3: Selector 4'b0010 makes the result the sum of the operands modulo 2^32. A carry out of the top bit is discarded and no overflow output exists.
- R4: Selector 4'b0110 makes the result operand A minus operand B modulo 2^32. A borrow wraps around.
- R5: Selector 4'b0111 makes the result 32'd1 when A is less than B as signed two's-complement numbers, and 32'd0 otherwise. Bits 31:1 of the result are always zero for this selector.
- R6: Selector 4'b1100 makes the result the bitwise complement of (A OR B).
- R7: Any selector value other than 0000, 0001, 0010, 0110, 0111 and 1100 makes the result 32'd0, whatever the operands are.
- R8: The zero flag is 1 exactly when all 32 result bits are 0, for every selector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| op_code | input | 4 | Operation selector |
| result | output | 32 | Operation result |
| is_zero | output | 1 | High when result is all zeros |

## Verification
Each operation is driven with operand pairs chosen to separate it from the others. Complementary bit patterns tell AND, OR and NOR apart. Carry-out and borrow cases show that arithmetic wraps instead of saturating. Equal operands show subtraction producing the zero flag that equal and not-equal branches rely on. The comparison is given pairs with opposite signs, on which a signed and an unsigned compare disagree, plus the most negative and most positive values, where the adder's difference overflows. Every unused selector is swept with non-zero operands to show that the result is forced to zero.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int ALU_W = 32;
    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND = 4'b0000,
        SEL_OR  = 4'b0001,
        SEL_ADD = 4'b0010,
        SEL_SUB = 4'b0110,
        SEL_SLT = 4'b0111,
        SEL_NOR = 4'b1100
    } alu_sel_e;

    // True when the adder must negate operand B
    function automatic logic needs_subtract(input logic [SEL_W-1:0] sel);
        return (sel == SEL_SUB) || (sel == SEL_SLT);
    endfunction

endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] and_out,
    output logic [DATA_W-1:0] or_out,
    output logic [DATA_W-1:0] nor_out
);

    // One slice per bit position
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign and_out[i] = a_in[i] & b_in[i];
        assign or_out[i]  = a_in[i] | b_in[i];
        assign nor_out[i] = ~(a_in[i] | b_in[i]);
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              subtract,
    output logic [DATA_W-1:0] sum_out,
    output logic              less_signed
);

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] cin_vec;

    assign b_eff   = b_in ^ {DATA_W{subtract}};
    assign cin_vec = {{(DATA_W-1){1'b0}}, subtract};
    assign sum_out = a_in + b_eff + cin_vec;

    // Signed compare: differing signs decide directly, otherwise the difference sign
    always_comb begin
        if (a_in[DATA_W-1] != b_in[DATA_W-1]) begin
            less_signed = a_in[DATA_W-1];
        end else begin
            less_signed = sum_out[DATA_W-1];
        end
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int DATA_W  = 32,
    parameter int GROUP_W = 8
) (
    input  logic [DATA_W-1:0] value,
    output logic              all_zero
);

    localparam int N_GROUPS = (DATA_W + GROUP_W - 1) / GROUP_W;
    localparam int PAD_W    = N_GROUPS * GROUP_W;

    logic [PAD_W-1:0]    padded;
    logic [N_GROUPS-1:0] group_set;

    assign padded = {{(PAD_W-DATA_W){1'b0}}, value};

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        assign group_set[g] = |padded[g*GROUP_W +: GROUP_W];
    end

    assign all_zero = ~|group_set;

endmodule

// File: rtl/arith_logic_unit.sv
module arith_logic_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = ALU_W
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [SEL_W-1:0]  op_code,
    output logic [DATA_W-1:0] result,
    output logic              is_zero
);

    logic [DATA_W-1:0] and_v;
    logic [DATA_W-1:0] or_v;
    logic [DATA_W-1:0] nor_v;
    logic [DATA_W-1:0] arith_v;
    logic              lt_v;
    logic              do_sub;

    assign do_sub = needs_subtract(op_code);

    alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .and_out (and_v),
        .or_out  (or_v),
        .nor_out (nor_v)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_in        (opnd_a),
        .b_in        (opnd_b),
        .subtract    (do_sub),
        .sum_out     (arith_v),
        .less_signed (lt_v)
    );

    always_comb begin
        case (op_code)
            SEL_AND: result = and_v;
            SEL_OR:  result = or_v;
            SEL_ADD: result = arith_v;
            SEL_SUB: result = arith_v;
            SEL_SLT: result = {{(DATA_W-1){1'b0}}, lt_v};
            SEL_NOR: result = nor_v;
            default: result = '0;
        endcase
    end

    alu_zero_detect #(.DATA_W(DATA_W), .GROUP_W(8)) u_zero (
        .value    (result),
        .all_zero (is_zero)
    );

endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
    parameter int DATA_W = 32
) (
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] result,
    input logic              is_zero
);

    always_comb begin
        // R1
        if (op_code == 4'b0000) and_op_chk: assert (result == (opnd_a & opnd_b)) else $error("and_op_chk");
        // R2
        if (op_code == 4'b0001) or_op_chk: assert (result == (opnd_a | opnd_b)) else $error("or_op_chk");
        // R3
        if (op_code == 4'b0010) add_op_chk: assert (result - opnd_b == opnd_a) else $error("add_op_chk");
        // R4
        if (op_code == 4'b0110) sub_op_chk: assert (result + opnd_b == opnd_a) else $error("sub_op_chk");
        // R5
        if (op_code == 4'b0111) slt_op_chk: assert (result == (($signed(opnd_a) < $signed(opnd_b)) ? 1 : 0)) else $error("slt_op_chk");
        // R6
        if (op_code == 4'b1100) nor_op_chk: assert ((result & (opnd_a | opnd_b)) == '0 && (result | opnd_a | opnd_b) == '1) else $error("nor_op_chk");
        // R7
        if (!(op_code inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100}))
            unused_sel_chk: assert (result == '0 && is_zero) else $error("unused_sel_chk");
        // R8
        zero_flag_chk: assert (is_zero == ($countones(result) == 0)) else $error("zero_flag_chk");
    end

endmodule

bind arith_logic_unit alu_checker #(.DATA_W(DATA_W)) u_alu_checker (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_code (op_code),
    .result  (result),
    .is_zero (is_zero)
);

// File: tb/tb_arith_logic_unit.sv
module tb_arith_logic_unit;

    logic        clk = 1'b0;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [3:0]  op_code;
    logic [31:0] result;
    logic        is_zero;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    arith_logic_unit dut (
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .op_code (op_code),
        .result  (result),
        .is_zero (is_zero)
    );

    // Drive on the falling edge, sample just before the next rising edge
    task automatic apply(input logic [3:0] sel, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_code = sel;
        opnd_a  = a;
        opnd_b  = b;
        #5;
    endtask

    task automatic check(input string req, input logic [31:0] exp_res);
        logic exp_z;
        exp_z = (exp_res == 32'd0);
        checks++;
        if (result !== exp_res) begin
            errors++;
            $display("FAIL %s result actual=%h expected=%h", req, result, exp_res);
        end
        checks++;
        if (is_zero !== exp_z) begin
            errors++;
            $display("FAIL R8 (%s) zero flag actual=%b expected=%b", req, is_zero, exp_z);
        end
    endtask

    task automatic run_one(input string req, input logic [3:0] sel,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] exp_res);
        apply(sel, a, b);
        check(req, exp_res);
    endtask

    task automatic t_idle;
        run_one("R1 idle", 4'b0000, 32'h0, 32'h0, 32'h0);
    endtask

    task automatic t_and;
        run_one("R1", 4'b0000, 32'hF0F0_1234, 32'hFF00_FFFF, 32'hF000_1234);
        run_one("R1", 4'b0000, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0);
    endtask

    task automatic t_or;
        run_one("R2", 4'b0001, 32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF);
        run_one("R2", 4'b0001, 32'h0000_0010, 32'h0100_0000, 32'h0100_0010);
    endtask

    task automatic t_add;
        run_one("R3", 4'b0010, 32'd1000, 32'd234, 32'd1234);
        run_one("R3", 4'b0010, 32'hFFFF_FFFF, 32'd1, 32'h0);
        run_one("R3", 4'b0010, 32'h7FFF_FFFF, 32'd1, 32'h8000_0000);
    endtask

    task automatic t_sub;
        run_one("R4", 4'b0110, 32'd50, 32'd8, 32'd42);
        run_one("R4", 4'b0110, 32'd0, 32'd1, 32'hFFFF_FFFF);
        run_one("R4 equal", 4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0);
    endtask

    task automatic t_slt;
        run_one("R5", 4'b0111, 32'd3, 32'd7, 32'd1);
        run_one("R5", 4'b0111, 32'd7, 32'd3, 32'd0);
        run_one("R5 equal", 4'b0111, 32'd9, 32'd9, 32'd0);
        run_one("R5 signed", 4'b0111, 32'hFFFF_FFFF, 32'd1, 32'd1);
        run_one("R5 signed", 4'b0111, 32'd1, 32'hFFFF_FFFF, 32'd0);
        run_one("R5 extreme", 4'b0111, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1);
        run_one("R5 extreme", 4'b0111, 32'h7FFF_FFFF, 32'h8000_0000, 32'd0);
    endtask

    task automatic t_nor;
        run_one("R6", 4'b1100, 32'h0, 32'h0, 32'hFFFF_FFFF);
        run_one("R6", 4'b1100, 32'hF0F0_0000, 32'h0000_0F0F, 32'h0F0F_F0F0);
        run_one("R6", 4'b1100, 32'hFFFF_0000, 32'h0000_FFFF, 32'h0);
    endtask

    task automatic t_unused;
        for (int s = 0; s < 16; s++) begin
            if (!(s inside {0, 1, 2, 6, 7, 12})) begin
                run_one("R7", 4'(s), 32'h1234_5678, 32'h8765_4321, 32'h0);
            end
        end
    endtask

    initial begin
        op_code = 4'b0000;
        opnd_a  = '0;
        opnd_b  = '0;
        repeat (2) @(posedge clk);
        t_idle();
        t_and();
        t_or();
        t_add();
        t_sub();
        t_slt();
        t_nor();
        t_unused();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule